// File: doc/BRIEF.md
# Accumulator Processor with Compare-and-Branch

The block is a small multi-cycle processor built around one 16-bit accumulator. It fetches 16-bit instruction words from a synchronous, word-addressed memory. Each word holds a 4-bit opcode and a 12-bit operand. The 14 defined operations are load, store, add, subtract, port input, port output, an unconditional jump, a jump on negative accumulator, a signed compare, three jumps that test the compare result, a no-op and halt.

The memory port is fully registered: address, write data and write enable all come from flops. Read data is expected one clock after the address. The 12-bit operand of a port instruction selects the port and appears on the I/O address output. A one-cycle strobe marks each port transfer. After a halt the processor stops fetching and does nothing until synchronous reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mem_addr` is 0 and `halted`, `mem_we`, `in_strobe` and `out_strobe` are all 0. Execution starts at word 0 with the accumulator at 0 and all compare results cleared, so no compare-jump is taken before the first compare.
- R2: Bits [15:12] of an instruction word are the opcode and bits [11:0] are the operand. For port instructions the full 12-bit operand appears on `io_addr`.
- R3: Opcode 1 loads the memory word at the operand address into the accumulator. Opcode 2 writes the accumulator to that address, with `mem_we` high for exactly one cycle.
- R4: Opcode 3 adds the addressed memory word to the accumulator and opcode 4 subtracts it. Both wrap modulo 2^16.
- R5: Opcode 5 loads the accumulator with `in_data` zero-extended. `in_strobe` is high for exactly the one cycle in which `in_data` is sampled, and it is never high together with `out_strobe`.
- R6: Opcode 6 drives `out_data` with accumulator bits [7:0] and raises `out_strobe` for exactly one cycle, while `io_addr` holds the operand.
- R7: Opcode 7 always jumps to the operand address. Opcode 8 jumps only when accumulator bit 15 is 1.
- R8: Opcode A compares the accumulator with the addressed word as signed numbers. It sets exactly one of greater, equal and less, and leaves the accumulator unchanged. Opcodes B, C and D jump when greater, equal or less, respectively, was the last compare result.
- R9: Opcode 9 raises `halted`. From then until reset, `halted` stays high, `mem_addr` does not change and no write or strobe occurs.
- R10: Opcodes 0, E and F change nothing except advancing to the next word.
- R11: A memory-reading instruction (1, 3, 4, A) takes 4 cycles and every other instruction takes 3. `halted` rises 2 cycles after the halt word's fetch cycle begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (registered) |
| mem_wdata | output | 16 | Memory write data (registered) |
| mem_we | output | 1 | Memory write enable (registered) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_data | input | 8 | Input port data |
| in_strobe | output | 1 | High in the cycle `in_data` is sampled |
| out_data | output | 8 | Output port data |
| out_strobe | output | 1 | One-cycle output port pulse |
| io_addr | output | 12 | Port number of the current port instruction |
| halted | output | 1 | Fetch stopped by a halt instruction |

## Verification
The bench goes after signed comparison across the sign boundary, such as 0x80F3 against 1. A design that compared unsigned would take the greater branch there. It checks that compare leaves the accumulator alone, because a compare built from the subtractor could overwrite it. It checks that add and subtract wrap at 16 bits, and that opcodes E and F do nothing. A decoder that treated F as a store would corrupt memory at 0xFFF, and the full-memory comparison catches that. Cycle counts to halt are checked for every program, so a missing or extra wait state shows up. So do flags left over after reset, strobes that last more than one cycle, and any activity after halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LOAD = 4'h1,
    OP_STOR = 4'h2,
    OP_ADD  = 4'h3,
    OP_SUB  = 4'h4,
    OP_IN   = 4'h5,
    OP_OUT  = 4'h6,
    OP_JMP  = 4'h7,
    OP_JNEG = 4'h8,
    OP_HALT = 4'h9,
    OP_CMP  = 4'hA,
    OP_JGT  = 4'hB,
    OP_JEQ  = 4'hC,
    OP_JLT  = 4'hD,
    OP_RSVE = 4'hE,
    OP_RSVF = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_EXEC   = 3'd3,
    ST_HALT   = 3'd4
  } cpu_state_e;

  // compare result bit positions inside the flag vector
  localparam int FLG_GT = 2;
  localparam int FLG_EQ = 1;
  localparam int FLG_LT = 0;

  function automatic logic reads_memory(input opcode_e op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opcode_e    dec_op,
  output cpu_state_e state
);

  cpu_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: begin
        if (dec_op == OP_HALT)         state_nx = ST_HALT;
        else if (reads_memory(dec_op)) state_nx = ST_WAIT;
        else                           state_nx = ST_EXEC;
      end
      ST_WAIT:   state_nx = ST_EXEC;
      ST_EXEC:   state_nx = ST_FETCH;
      ST_HALT:   state_nx = ST_HALT;
      default:   state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= state_nx;
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic [2:0]        cmp
);
  import acc_cpu_pkg::*;

  always_comb begin
    sum  = acc + opnd;
    diff = acc - opnd;
    cmp  = '0;
    if ($signed(acc) > $signed(opnd))      cmp[FLG_GT] = 1'b1;
    else if ($signed(acc) < $signed(opnd)) cmp[FLG_LT] = 1'b1;
    else                                   cmp[FLG_EQ] = 1'b1;
  end

endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
  import acc_cpu_pkg::*;
(
  input  opcode_e    op,
  input  logic       acc_neg,
  input  logic [2:0] flags,
  output logic       taken
);

  always_comb begin
    case (op)
      OP_JMP:  taken = 1'b1;
      OP_JNEG: taken = acc_neg;
      OP_JGT:  taken = flags[FLG_GT];
      OP_JEQ:  taken = flags[FLG_EQ];
      OP_JLT:  taken = flags[FLG_LT];
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PORT_W = 8,
  parameter int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [PORT_W-1:0] in_data,
  output logic              in_strobe,
  output logic [PORT_W-1:0] out_data,
  output logic              out_strobe,
  output logic [ADDR_W-1:0] io_addr,
  output logic              halted
);

  localparam int EXT_W = DATA_W - PORT_W;

  cpu_state_e        state;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] ir;
  logic [2:0]        cmp_flags;

  opcode_e           fetch_op;
  logic [ADDR_W-1:0] fetch_arg;
  opcode_e           ir_op;
  logic [ADDR_W-1:0] ir_arg;

  logic [DATA_W-1:0] alu_sum;
  logic [DATA_W-1:0] alu_diff;
  logic [2:0]        alu_cmp;
  logic              jump_taken;

  assign fetch_op  = opcode_e'(mem_rdata[DATA_W-1 -: OPC_W]);
  assign fetch_arg = mem_rdata[ADDR_W-1:0];
  assign ir_op     = opcode_e'(ir[DATA_W-1 -: OPC_W]);
  assign ir_arg    = ir[ADDR_W-1:0];

  acc_cpu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .dec_op (fetch_op),
    .state  (state)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .acc  (acc),
    .opnd (mem_rdata),
    .sum  (alu_sum),
    .diff (alu_diff),
    .cmp  (alu_cmp)
  );

  acc_cpu_branch u_branch (
    .op      (ir_op),
    .acc_neg (acc[DATA_W-1]),
    .flags   (cmp_flags),
    .taken   (jump_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      acc        <= '0;
      ir         <= '0;
      cmp_flags  <= '0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_we     <= 1'b0;
      in_strobe  <= 1'b0;
      out_strobe <= 1'b0;
      out_data   <= '0;
      io_addr    <= '0;
      halted     <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      in_strobe  <= 1'b0;
      out_strobe <= 1'b0;
      case (state)
        ST_DECODE: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          case (fetch_op)
            OP_LOAD, OP_ADD, OP_SUB, OP_CMP: mem_addr <= fetch_arg;
            OP_STOR: begin
              mem_addr  <= fetch_arg;
              mem_wdata <= acc;
              mem_we    <= 1'b1;
            end
            OP_IN: begin
              io_addr   <= fetch_arg;
              in_strobe <= 1'b1;
            end
            OP_OUT: begin
              io_addr    <= fetch_arg;
              out_data   <= acc[PORT_W-1:0];
              out_strobe <= 1'b1;
            end
            OP_HALT: halted <= 1'b1;
            default: ;
          endcase
        end
        ST_EXEC: begin
          case (ir_op)
            OP_LOAD: acc       <= mem_rdata;
            OP_ADD:  acc       <= alu_sum;
            OP_SUB:  acc       <= alu_diff;
            OP_IN:   acc       <= {{EXT_W{1'b0}}, in_data};
            OP_CMP:  cmp_flags <= alu_cmp;
            default: ;
          endcase
          if (jump_taken) begin
            pc       <= ir_arg;
            mem_addr <= ir_arg;
          end else begin
            mem_addr <= pc;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              in_strobe,
  input logic              out_strobe,
  input logic              halted,
  input logic [2:0]        cmp_flags
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && !halted && !mem_we && !in_strobe && !out_strobe)); // R1

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R3

  AST_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    in_strobe |=> !in_strobe); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(in_strobe && out_strobe)); // R5

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_strobe |=> !out_strobe); // R6

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmp_flags)); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R9

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !in_strobe && !out_strobe)); // R9

  AST_HALT_ADDR: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr)); // R9

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_addr   (mem_addr),
  .mem_we     (mem_we),
  .in_strobe  (in_strobe),
  .out_strobe (out_strobe),
  .halted     (halted),
  .cmp_flags  (cmp_flags)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  localparam int DW    = 16;
  localparam int AW    = 12;
  localparam int PW    = 8;
  localparam int MEMSZ = 1 << AW;
  localparam int MAXO  = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic [PW-1:0] in_data;
  logic          in_strobe;
  logic [PW-1:0] out_data;
  logic          out_strobe;
  logic [AW-1:0] io_addr;
  logic          halted;
  logic [7:0]    in_key = 8'h00;

  always #10 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_strobe(in_strobe), .out_data(out_data), .out_strobe(out_strobe),
    .io_addr(io_addr), .halted(halted)
  );

  logic [DW-1:0] mem [0:MEMSZ-1];
  logic [DW-1:0] img [0:MEMSZ-1];
  logic [DW-1:0] mm  [0:MEMSZ-1];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  assign in_data = io_addr[7:0] ^ in_key;

  int n_chk = 0;
  int n_fail = 0;

  int         n_got, n_in_got;
  logic [7:0] got_d [0:MAXO-1];
  logic [11:0] got_p [0:MAXO-1];
  int         exp_n, exp_nin, exp_cyc;
  logic [7:0] exp_d [0:MAXO-1];
  logic [11:0] exp_p [0:MAXO-1];

  always @(negedge clk) begin
    if (!rst) begin
      if (out_strobe) begin
        if (n_got < MAXO) begin
          got_d[n_got] = out_data;
          got_p[n_got] = io_addr;
        end
        n_got++;
      end
      if (in_strobe) n_in_got++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < MEMSZ; i++) img[i] = '0;
  endtask

  // instruction-level reference model, written from the requirements
  task automatic model_run();
    logic [11:0] pc;
    logic [15:0] acc, w, v;
    logic [3:0]  op;
    logic [11:0] a;
    bit gt, eq, lt, done;
    pc = '0; acc = '0; gt = 0; eq = 0; lt = 0; done = 0;
    exp_n = 0; exp_nin = 0; exp_cyc = 0;
    for (int i = 0; i < MEMSZ; i++) mm[i] = img[i];
    for (int step = 0; step < 4000 && !done; step++) begin
      w = mm[pc]; op = w[15:12]; a = w[11:0]; pc = pc + 12'd1;
      v = mm[a];
      case (op)
        4'h1: begin acc = v; exp_cyc += 4; end
        4'h2: begin mm[a] = acc; exp_cyc += 3; end
        4'h3: begin acc = acc + v; exp_cyc += 4; end
        4'h4: begin acc = acc - v; exp_cyc += 4; end
        4'h5: begin acc = {8'h00, a[7:0] ^ in_key}; exp_nin++; exp_cyc += 3; end
        4'h6: begin
          if (exp_n < MAXO) begin exp_d[exp_n] = acc[7:0]; exp_p[exp_n] = a; end
          exp_n++; exp_cyc += 3;
        end
        4'h7: begin pc = a; exp_cyc += 3; end
        4'h8: begin if (acc[15]) pc = a; exp_cyc += 3; end
        4'h9: begin exp_cyc += 2; done = 1; end
        4'hA: begin
          gt = $signed(acc) > $signed(v);
          lt = $signed(acc) < $signed(v);
          eq = (acc == v);
          exp_cyc += 4;
        end
        4'hB: begin if (gt) pc = a; exp_cyc += 3; end
        4'hC: begin if (eq) pc = a; exp_cyc += 3; end
        4'hD: begin if (lt) pc = a; exp_cyc += 3; end
        default: exp_cyc += 3;
      endcase
    end
  endtask

  task automatic run_prog(input string tag);
    int cnt, bad, first;
    bit quiet;
    logic [AW-1:0] held;
    model_run();
    rst = 1'b1;
    for (int i = 0; i < MEMSZ; i++) mem[i] = img[i];
    repeat (3) @(negedge clk);
    n_got = 0; n_in_got = 0;
    check(mem_addr == '0 && !halted && !mem_we && !in_strobe && !out_strobe,
          "R1", "reset outputs", {mem_addr, halted, mem_we, in_strobe, out_strobe}, 0);
    rst = 1'b0;
    cnt = 0;
    while (!halted && cnt < 5000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    check(cnt == exp_cyc, "R11", {tag, " cycles to halt"}, cnt, exp_cyc);
    held = mem_addr; quiet = 1;
    repeat (12) begin
      @(negedge clk);
      if (!halted || mem_we || in_strobe || out_strobe || mem_addr != held) quiet = 0;
    end
    check(quiet, "R9", {tag, " halted quiet"}, quiet, 1);
    check(n_got == exp_n, "R6", {tag, " output count"}, n_got, exp_n);
    for (int i = 0; i < n_got && i < exp_n && i < MAXO; i++)
      check(got_d[i] == exp_d[i] && got_p[i] == exp_p[i], tag, "output data/port",
            {got_p[i], got_d[i]}, {exp_p[i], exp_d[i]});
    check(n_in_got == exp_nin, "R5", {tag, " input strobes"}, n_in_got, exp_nin);
    bad = 0; first = 0;
    for (int i = 0; i < MEMSZ; i++)
      if (mem[i] !== mm[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    check(bad == 0, "R3", {tag, " memory image"}, first, bad == 0 ? 0 : mm[first]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=halt");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    int pl;
    logic [3:0] op;
    logic [11:0] a;
    seed = $urandom(32'd24680);

    // R4: wrap of add and subtract
    clear_img();
    img[64] = 16'hFFFF; img[65] = 16'h0002;
    img[0] = ins(4'h1, 64); img[1] = ins(4'h3, 65); img[2] = ins(4'h6, 1);
    img[3] = ins(4'h2, 70); img[4] = ins(4'h4, 65); img[5] = ins(4'h4, 65);
    img[6] = ins(4'h6, 2);  img[7] = ins(4'h2, 71); img[8] = ins(4'h9, 0);
    run_prog("R4");

    // R1: accumulator and flags cleared by reset after a program that set them
    clear_img();
    img[64] = 16'h1234;
    img[0] = ins(4'h1, 64); img[1] = ins(4'hA, 64); img[2] = ins(4'h9, 0);
    run_prog("R1");
    clear_img();
    img[0] = ins(4'h6, 1); img[1] = ins(4'hC, 5); img[2] = ins(4'hB, 5);
    img[3] = ins(4'hD, 5); img[4] = ins(4'h6, 2); img[5] = ins(4'h9, 0);
    run_prog("R1");

    // R8: signed compare, accumulator untouched, three compare-jumps
    clear_img();
    img[64] = 16'h80F3; img[65] = 16'h0001;
    img[0]  = ins(4'h1, 64);  img[1]  = ins(4'hA, 65);  img[2]  = ins(4'hD, 4);
    img[3]  = ins(4'h6, 'hEE); img[4] = ins(4'h6, 'h11); img[5]  = ins(4'h8, 7);
    img[6]  = ins(4'h6, 'hEE); img[7] = ins(4'hA, 64);  img[8]  = ins(4'hC, 10);
    img[9]  = ins(4'h6, 'hEE); img[10] = ins(4'h1, 65); img[11] = ins(4'hA, 64);
    img[12] = ins(4'hB, 14);  img[13] = ins(4'h6, 'hEE); img[14] = ins(4'h6, 'h22);
    img[15] = ins(4'h9, 0);
    run_prog("R8");

    // R7: unconditional jump and sign test
    clear_img();
    img[65] = 16'h0001; img[66] = 16'h0002;
    img[0] = ins(4'h1, 65); img[1] = ins(4'h8, 3);    img[2] = ins(4'h6, 'h31);
    img[3] = ins(4'h7, 5);  img[4] = ins(4'h6, 'hEE); img[5] = ins(4'h4, 66);
    img[6] = ins(4'h8, 8);  img[7] = ins(4'h6, 'hEE); img[8] = ins(4'h6, 'h32);
    img[9] = ins(4'h9, 0);
    run_prog("R7");

    // R10: opcodes 0, E and F have no effect
    clear_img();
    img[64] = 16'h1234; img[MEMSZ-1] = 16'h5A5A;
    img[0] = ins(4'h1, 64); img[1] = 16'hE123; img[2] = 16'hFFFF;
    img[3] = 16'h0ABC;      img[4] = ins(4'h6, 1); img[5] = ins(4'hA, 64);
    img[6] = 16'hF000;      img[7] = ins(4'hC, 9); img[8] = ins(4'h6, 'hEE);
    img[9] = ins(4'h2, 72); img[10] = ins(4'h9, 0);
    run_prog("R10");

    // R2 / R5: full 12-bit port operands, zero-extended input
    clear_img();
    in_key = 8'h3C;
    img[0] = ins(4'h5, 'hABC); img[1] = ins(4'h6, 'hDEF);
    img[2] = ins(4'h2, 73);    img[3] = ins(4'h9, 0);
    run_prog("R2");

    // random forward-branching programs
    for (int t = 0; t < 25; t++) begin
      clear_img();
      in_key = 8'($urandom);
      pl = 24;
      for (int i = 64; i < 80; i++) img[i] = 16'($urandom);
      for (int i = 0; i < pl; i++) begin
        op = 4'($urandom);
        if (op == 4'h9) op = 4'h3;
        case (op)
          4'h7, 4'h8, 4'hB, 4'hC, 4'hD: a = 12'(i + 1 + ($urandom % (pl - i)));
          4'h1, 4'h2, 4'h3, 4'h4, 4'hA: a = 12'(64 + ($urandom % 16));
          default: a = 12'($urandom);
        endcase
        img[i] = ins(op, a);
      end
      img[pl] = ins(4'h9, 0);
      run_prog("R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule